// File: doc/BRIEF.md
# Latched-Address 4-to-16 Decoder

This block turns a binary address into a single selected line out of sixteen. All outputs are active low, and at most one of them is low at any time. A capture control sets how the address reaches the decoder. While capture is high, the live address feeds the decoder directly, so the selected output follows the address pins within the same cycle. A clocked register also loads the address on every rising edge while capture is high. When capture drops, the decoder reads that register instead, so later changes on the address pins have no effect.

An active-low enable gates only the sixteen outputs. With the enable high, every output is high. The enable never changes the held address. The block can also work as a demultiplexer. In that use, a serial data stream drives the enable pin and the address picks which output copies it. A synchronous active-low reset clears the held address to zero. Reset never forces an output low, because the enable alone decides whether any output is low.

Top module: `addr_latch_decoder`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) clears the held address to 0. With capture low and en_n low after reset, only sel_n_o[0] is low.
- R2: At most one bit of sel_n_o is low at any time.
- R3: While capture_i is high and en_n_i is low, sel_n_o[addr_i] is low in the same cycle as the address is applied, with no clock edge needed.
- R4: While capture_i is low, the decoder uses the address sampled at the last rising edge at which capture_i was high. Changes on addr_i during that time leave sel_n_o unchanged.
- R5: While en_n_i is high, all sixteen bits of sel_n_o are high, whatever the address or capture state.
- R6: en_n_i has no effect on the held address. After en_n_i goes high and then low again during a hold, the same output is selected as before.
- R7: In demultiplexer use (capture_i high, address fixed at a), sel_n_o[a] equals en_n_i and every other bit is high.
- R8: The address is binary weighted with addr_i[0] as the least significant bit, and bit i of sel_n_o is output i. The address value k selects bit k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the address register |
| rst_n | input | 1 | Synchronous active-low reset that clears the held address |
| addr_i | input | 4 | Binary address; bit 0 is the LSB |
| capture_i | input | 1 | High: the address passes straight through and is loaded each clock edge. Low: the held address is used |
| en_n_i | input | 1 | Active-low output enable; carries the data in demultiplexer use |
| sel_n_o | output | 16 | Active-low, mutually exclusive select outputs; bit i is output i |

## Verification
A wrong held address cannot be seen while capture is high, because the bypass hides it. It appears at the ports in the first cycle after capture falls, as the wrong low bit, so the bench checks the outputs right after each release and again after the address pins are disturbed. A fault in the decoder or the gating shows up at once, in the same cycle, as a missing low bit, a low bit at the wrong place or two low bits. The full address sweep in both pass-through and hold exposes these faults. Reference values are computed arithmetically from the address and the enable.

// File: rtl/ald_pkg.sv
package ald_pkg;

   // Implementation choices for the one-hot stage.
   typedef enum logic {
      DEC_COMPARE = 1'b0,   // one equality comparator per output line
      DEC_SHIFT   = 1'b1    // single barrel shift of a one
   } dec_style_e;

   // Number of output lines for a given address width.
   function automatic int line_count(input int aw);
      return 1 << aw;
   endfunction

endpackage

// File: rtl/ald_addr_hold.sv
// Address holding stage: clocked capture register plus a transparent bypass.
module ald_addr_hold #(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              capture_i,
   output logic [ADDR_W-1:0] idx_o
);

   logic [ADDR_W-1:0] held_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         held_q <= '0;
      else if (capture_i)
         held_q <= addr_i;
   end

   // Capture high: live address; capture low: stored value.
   always_comb begin
      idx_o = capture_i ? addr_i : held_q;
   end

   // R6 / R4: the stored address only moves after a capture cycle.
   p_held_only_on_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(capture_i)) |-> $stable(held_q));

   // R4: in hold, the decode index is steady from cycle to cycle.
   p_hold_index_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !capture_i && !$past(capture_i)) |-> $stable(idx_o));

endmodule

// File: rtl/ald_onehot.sv
// Binary to one-hot conversion; DEC_STYLE picks the structure.
module ald_onehot
   import ald_pkg::*;
#(
   parameter int         ADDR_W    = 4,
   parameter dec_style_e DEC_STYLE = DEC_COMPARE
) (
   input  logic [ADDR_W-1:0]         idx_i,
   output logic [(1 << ADDR_W)-1:0]  hot_o
);

   localparam int LINES = line_count(ADDR_W);

   generate
      if (DEC_STYLE == DEC_COMPARE) begin : g_compare
         for (genvar i = 0; i < LINES; i++) begin : g_line
            assign hot_o[i] = (idx_i == ADDR_W'(i));
         end
      end else begin : g_shift
         assign hot_o = {{(LINES-1){1'b0}}, 1'b1} << idx_i;
      end
   endgenerate

   // R2 / R8: exactly one line is hot for any known index.
   always_comb begin
      if (!$isunknown(idx_i)) begin
         p_one_hot_r2: assert ($onehot(hot_o));
      end
   end

endmodule

// File: rtl/ald_out_gate.sv
// Active-low output gating driven by the enable only.
module ald_out_gate #(
   parameter int LINES = 16
) (
   input  logic [LINES-1:0] hot_i,
   input  logic             en_n_i,
   output logic [LINES-1:0] sel_n_o
);

   always_comb begin
      sel_n_o = ~(hot_i & {LINES{~en_n_i}});
   end

   // R5: a high enable leaves every line high.
   always_comb begin
      if (en_n_i === 1'b1) begin
         p_disabled_all_high_r5: assert (&sel_n_o);
      end
   end

endmodule

// File: rtl/addr_latch_decoder.sv
// Top: held-address 1-of-N decoder / demultiplexer with active-low outputs.
module addr_latch_decoder
   import ald_pkg::*;
#(
   parameter int         ADDR_W    = 4,
   parameter dec_style_e DEC_STYLE = DEC_COMPARE
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [ADDR_W-1:0]                 addr_i,
   input  logic                              capture_i,
   input  logic                              en_n_i,
   output logic [ald_pkg::line_count(ADDR_W)-1:0] sel_n_o
);

   localparam int LINES = line_count(ADDR_W);

   generate
      if (ADDR_W < 1 || ADDR_W > 8) begin : g_bad_width
         $error("addr_latch_decoder: ADDR_W must lie in 1..8");
      end
   endgenerate

   logic [ADDR_W-1:0] idx;
   logic [LINES-1:0]  hot;

   ald_addr_hold #(.ADDR_W(ADDR_W)) u_hold (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_i    (addr_i),
      .capture_i (capture_i),
      .idx_o     (idx)
   );

   ald_onehot #(.ADDR_W(ADDR_W), .DEC_STYLE(DEC_STYLE)) u_dec (
      .idx_i (idx),
      .hot_o (hot)
   );

   ald_out_gate #(.LINES(LINES)) u_gate (
      .hot_i   (hot),
      .en_n_i  (en_n_i),
      .sel_n_o (sel_n_o)
   );

   // R2: outputs mutually exclusive.
   p_mutex_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~sel_n_o));

   // R3 / R7: pass-through selects the live address, and that line copies the enable.
   p_pass_through_r3: assert property (@(posedge clk) disable iff (!rst_n)
      capture_i |-> (sel_n_o[addr_i] == en_n_i));

   // R5: enable high forces all lines high.
   p_disabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
      en_n_i |-> (&sel_n_o));

   // R4: in hold, with a steady enable, the outputs do not move.
   p_hold_outputs_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !capture_i && !$past(capture_i) && $stable(en_n_i))
      |-> $stable(sel_n_o));

endmodule

// File: tb/tb_addr_latch_decoder.sv
module tb_addr_latch_decoder;

   localparam int AW = 4;
   localparam int NL = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          cap = 1'b0;
   logic          en_n = 1'b1;
   logic [NL-1:0] sel_n;

   int  n_checks = 0;
   int  n_fails  = 0;
   bit  done     = 1'b0;
   logic [AW-1:0] m_held = '0;

   always #10 clk = ~clk;   // 50 MHz

   addr_latch_decoder #(.ADDR_W(AW)) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr_i    (addr),
      .capture_i (cap),
      .en_n_i    (en_n),
      .sel_n_o   (sel_n)
   );

   // Reference model of the held address, written from the requirements.
   always @(posedge clk) begin
      if (!rst_n)   m_held <= '0;
      else if (cap) m_held <= addr;
   end

   function automatic logic [NL-1:0] expect_out(input logic [AW-1:0] a,
                                                input logic c, input logic e,
                                                input logic [AW-1:0] h);
      logic [AW-1:0] k;
      k = c ? a : h;
      if (e) return '1;
      return ~(NL'(1) << k);
   endfunction

   task automatic check(input string req);
      logic [NL-1:0] exp;
      exp = expect_out(addr, cap, en_n, m_held);
      n_checks++;
      if (sel_n !== exp) begin
         n_fails++;
         $display("FAIL %s: sel_n_o=%h expected %h (addr=%0d cap=%b en_n=%b)",
                  req, sel_n, exp, addr, cap, en_n);
      end
   endtask

   // Drive at the falling edge, sample 2 ns later.
   task automatic step(input logic [AW-1:0] a, input logic c, input logic e,
                       input string req);
      @(negedge clk);
      addr = a; cap = c; en_n = e;
      #2;
      check(req);
   endtask

   initial begin
      // R5 and R1: disabled during reset, then line 0 after reset.
      rst_n = 1'b0;
      step(4'd7, 1'b0, 1'b1, "R5");
      step(4'd3, 1'b0, 1'b1, "R5");
      @(negedge clk); rst_n = 1'b1;
      step(4'd11, 1'b0, 1'b0, "R1");
      if (sel_n !== ~(NL'(1))) begin
         n_fails++;
         $display("FAIL R1: sel_n_o=%h expected %h", sel_n, ~(NL'(1)));
      end
      n_checks++;

      // R3, R8, R2: sweep all addresses in pass-through.
      for (int i = 0; i < NL; i++) begin
         step(AW'(i), 1'b1, 1'b0, "R3");
         n_checks++;
         if ($countones(~sel_n) != 1 || sel_n[i] !== 1'b0) begin
            n_fails++;
            $display("FAIL R8: sel_n_o=%h expected bit %0d low only", sel_n, i);
         end
      end

      // R4: capture 9, then release and disturb the address.
      step(4'd9, 1'b1, 1'b0, "R3");
      for (int i = 0; i < NL; i++) begin
         step(AW'(15 - i), 1'b0, 1'b0, "R4");
         n_checks++;
         if (sel_n !== ~(NL'(1) << 9)) begin
            n_fails++;
            $display("FAIL R4: sel_n_o=%h expected %h", sel_n, ~(NL'(1) << 9));
         end
      end

      // R5 then R6: enable high during the hold, then low again.
      for (int i = 0; i < 4; i++) step(AW'(i * 5), 1'b0, 1'b1, "R5");
      step(4'd2, 1'b0, 1'b0, "R6");
      n_checks++;
      if (sel_n !== ~(NL'(1) << 9)) begin
         n_fails++;
         $display("FAIL R6: sel_n_o=%h expected %h", sel_n, ~(NL'(1) << 9));
      end

      // Hold sweep: capture each address, then check it in hold.
      for (int i = 0; i < NL; i++) begin
         step(AW'(i), 1'b1, 1'b0, "R3");
         step(AW'(i ^ 5), 1'b0, 1'b0, "R4");
      end

      // R7: demultiplex a serial pattern onto line 5 and line 12.
      for (int d = 0; d < 2; d++) begin
         logic [7:0] pat;
         logic [AW-1:0] dst;
         pat = (d == 0) ? 8'b1011_0010 : 8'b0110_1101;
         dst = (d == 0) ? 4'd5 : 4'd12;
         for (int b = 0; b < 8; b++) begin
            step(dst, 1'b1, pat[b], "R7");
            n_checks++;
            if (sel_n !== (~(NL'(1) << dst) | {NL{pat[b]}})) begin
               n_fails++;
               $display("FAIL R7: sel_n_o=%h expected %h", sel_n,
                        (~(NL'(1) << dst) | {NL{pat[b]}}));
            end
         end
      end

      // R1: mid-run reset with capture low returns to line 0.
      step(4'd13, 1'b1, 1'b0, "R3");
      @(negedge clk); cap = 1'b0; rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      #2;
      check("R1");
      step(4'd6, 1'b0, 1'b0, "R1");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end

endmodule